// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block shifts a configuration bitstream into a programmable-logic device that listens on a two-wire slave-serial link: a configuration clock and a configuration data line. A single start pulse latches a word count and a byte-order option. The block then runs a fixed bring-up sequence. It turns on the target's supply enable and waits for the supply to settle. It holds the idle levels on the link for a short quiet time. It pulses the active-low configuration reset. After that it takes words one at a time over a valid/ready handshake and clocks every bit out.

Each 32-bit word is split into byte lanes. Every byte leaves most significant bit first. The byte order within a word is either lowest lane first, which suits images stored as little-endian words, or highest lane first. A raw legacy image of 10,524 words opens with the sync words 0xFFFFFFFF and 0xAA995566 and needs the highest-lane-first order. All delays and the two clock phase lengths are cycle-count parameters, so the same block fits any system clock.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, supply enable, configuration clock, configuration data, ready, busy and done are all low, and the configuration reset is high.
- R2: The cycle after a start is accepted, the supply enable is high. The configuration reset stays high, with clock and data low, for PWR_WAIT_CYC + HOLD_CYC cycles. It then stays low for exactly PROG_LOW_CYC cycles and returns high before any clock pulse.
- R3: Every configuration clock pulse is high for exactly CCLK_HI_CYC cycles, and the clock stays low for at least CCLK_LO_CYC cycles before each rise. Data is stable in the cycle before each rise and through the whole high phase.
- R4: With the byte-order flag at 0, the word's bytes go out in the order bits [7:0], [15:8], [23:16], [31:24], and each byte goes out bit 7 first, one bit per clock rise.
- R5: With the byte-order flag at 1, the bytes go out in the order [31:24], [23:16], [15:8], [7:0], each byte still bit 7 first.
- R6: Ready is high only while the block waits for a word, which is after the reset pulse and after the last bit of the previous word. Exactly word-count words are taken, one per handshake. A word offered while ready is low is held off and not lost.
- R7: Busy is high from the cycle after the start until the last bit completes. Done is a one-cycle pulse in the first cycle that busy is low.
- R8: A word count of zero runs the full power and reset sequence, produces no clock pulse and no ready, and then signals done.
- R9: A start pulse while busy is ignored. The word count and byte-order flag are taken only at the accepted start.
- R10: Once raised, the supply enable stays high, including after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a load |
| word_count_i | input | CNT_W | Number of words to send, taken at start |
| byte_rev_i | input | 1 | Byte order: 0 lowest lane first, 1 highest lane first |
| word_data_i | input | WORD_W | Bitstream word |
| word_valid_i | input | 1 | Word offered |
| word_ready_o | output | 1 | Block can take a word this cycle |
| pwr_en_o | output | 1 | Target supply enable |
| cfg_reset_n_o | output | 1 | Active-low configuration reset to the target |
| cfg_clk_o | output | 1 | Configuration clock |
| cfg_data_o | output | 1 | Configuration data |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse when the load finishes |

## Verification
The bench sweeps word counts from zero to four, both byte orders and several word patterns. The patterns include the two legacy sync words, single set bits at lane edges, and spread values. The words arrive with varying handshake gaps. Each captured bit is compared with a value computed arithmetically from the word, lane order and bit position, so a swapped lane or an LSB-first byte shows up as a mismatch on a named word.

The reset-pulse timing is counted edge by edge, so an off-by-one in any delay stage shows as a wrong count. A zero word count catches a design that underflows its counter and runs 2^CNT_W words. A start pulse placed in the middle of a load catches a design that restarts, or that loads the new count and sends the wrong number of bits. Ready is watched across the whole run, so a block that takes words early or drops a held word shows up as a wrong handshake count or wrong data.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PWR   = 3'd1,
      ST_HOLD  = 3'd2,
      ST_PROG  = 3'd3,
      ST_FETCH = 3'd4,
      ST_SHIFT = 3'd5
   } cfgl_state_t;

   function automatic int cfgl_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic bit cfgl_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cfgl_delay.sv
module cfgl_delay #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/cfgl_lane_pick.sv
module cfgl_lane_pick #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8,
   parameter bit REV_EN = 1'b1,
   parameter int SEL_W  = $clog2(WORD_W / BYTE_W)
) (
   input  logic [WORD_W-1:0] word,
   input  logic              rev,
   input  logic [SEL_W-1:0]  seq,
   output logic [BYTE_W-1:0] lane
);

   localparam int LANES = WORD_W / BYTE_W;

   logic [BYTE_W-1:0] lanes [LANES];
   logic [SEL_W-1:0]  sel;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes[g] = word[g*BYTE_W +: BYTE_W];
   end

   if (REV_EN) begin : g_rev
      // LANES is a power of two, so ~seq is LANES-1-seq
      assign sel = rev ? ~seq : seq;
   end else begin : g_fwd
      logic unused_rev;
      assign unused_rev = rev;
      assign sel = seq;
   end

   assign lane = lanes[sel];

endmodule

// File: rtl/cfgl_bit_clock.sv
module cfgl_bit_clock #(
   parameter int HI_CYC = 1,
   parameter int LO_CYC = 1,
   parameter int BITS   = 32,
   parameter int IDX_W  = $clog2(BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   output logic             cclk,
   output logic             word_end,
   output logic [IDX_W-1:0] bit_idx
);

   localparam int PH_MAX = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
   localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;

   logic             act_q;
   logic             hi_q;
   logic [PH_W-1:0]  ph_q;
   logic [IDX_W-1:0] idx_q;
   logic             ph_end;

   assign ph_end   = (ph_q == '0);
   assign word_end = act_q && hi_q && ph_end && (idx_q == IDX_W'(BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         hi_q  <= 1'b0;
         ph_q  <= '0;
         idx_q <= '0;
      end else if (go) begin
         act_q <= 1'b1;
         hi_q  <= 1'b0;
         ph_q  <= PH_W'(LO_CYC - 1);
         idx_q <= '0;
      end else if (act_q && ph_end) begin
         if (!hi_q) begin
            hi_q <= 1'b1;
            ph_q <= PH_W'(HI_CYC - 1);
         end else if (word_end) begin
            act_q <= 1'b0;
            hi_q  <= 1'b0;
         end else begin
            hi_q  <= 1'b0;
            ph_q  <= PH_W'(LO_CYC - 1);
            idx_q <= idx_q + 1'b1;
         end
      end else if (act_q) begin
         ph_q <= ph_q - 1'b1;
      end
   end

   assign cclk    = act_q && hi_q;
   assign bit_idx = idx_q;

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
   parameter int WORD_W       = 32,
   parameter int BYTE_W       = 8,
   parameter int CNT_W        = 16,
   parameter int PWR_WAIT_CYC = 1_200_000,
   parameter int HOLD_CYC     = 24_000,
   parameter int PROG_LOW_CYC = 1_200_000,
   parameter int CCLK_HI_CYC  = 1,
   parameter int CCLK_LO_CYC  = 1,
   parameter bit REV_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  word_count_i,
   input  logic              byte_rev_i,
   input  logic [WORD_W-1:0] word_data_i,
   input  logic              word_valid_i,
   output logic              word_ready_o,
   output logic              pwr_en_o,
   output logic              cfg_reset_n_o,
   output logic              cfg_clk_o,
   output logic              cfg_data_o,
   output logic              busy_o,
   output logic              done_o
);
   import cfgl_pkg::*;

   localparam int LANES   = WORD_W / BYTE_W;
   localparam int SEL_W   = $clog2(LANES);
   localparam int LO_W    = $clog2(BYTE_W);
   localparam int IDX_W   = $clog2(WORD_W);
   localparam int DLY_MAX = cfgl_max3(PWR_WAIT_CYC, HOLD_CYC, PROG_LOW_CYC);
   localparam int TMR_W   = $clog2(DLY_MAX + 1);

   if (!cfgl_is_pow2(BYTE_W) || BYTE_W < 2) begin : g_bad_byte
      $error("BYTE_W must be a power of two of at least 2");
   end
   if (!cfgl_is_pow2(LANES) || LANES < 2 || (WORD_W % BYTE_W) != 0) begin : g_bad_word
      $error("WORD_W must hold a power-of-two count of at least two bytes");
   end
   if (PWR_WAIT_CYC < 1 || HOLD_CYC < 1 || PROG_LOW_CYC < 1) begin : g_bad_dly
      $error("sequence delays must be at least one cycle");
   end
   if (CCLK_HI_CYC < 1 || CCLK_LO_CYC < 1) begin : g_bad_clk
      $error("clock phases must be at least one cycle");
   end

   cfgl_state_t       st_q, st_d;
   logic [CNT_W-1:0]  left_q;
   logic              rev_q;
   logic              pwr_q;
   logic              done_q;
   logic [WORD_W-1:0] word_q;

   logic              tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_zero;
   logic              go;
   logic              take;
   logic              finish;
   logic              launch;
   logic              word_end;
   logic              clk_hi;
   logic [IDX_W-1:0]  bit_idx;
   logic [BYTE_W-1:0] lane;
   logic [LO_W-1:0]   msb_pos;

   cfgl_delay #(.W(TMR_W)) u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   cfgl_bit_clock #(
      .HI_CYC (CCLK_HI_CYC),
      .LO_CYC (CCLK_LO_CYC),
      .BITS   (WORD_W)
   ) u_bitclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .cclk     (clk_hi),
      .word_end (word_end),
      .bit_idx  (bit_idx)
   );

   cfgl_lane_pick #(
      .WORD_W (WORD_W),
      .BYTE_W (BYTE_W),
      .REV_EN (REV_EN)
   ) u_lane (
      .word (word_q),
      .rev  (rev_q),
      .seq  (bit_idx[IDX_W-1:LO_W]),
      .lane (lane)
   );

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      go       = 1'b0;
      take     = 1'b0;
      finish   = 1'b0;
      launch   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               launch   = 1'b1;
               st_d     = ST_PWR;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(PWR_WAIT_CYC - 1);
            end
         end
         ST_PWR: begin
            if (tmr_zero) begin
               st_d     = ST_HOLD;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(HOLD_CYC - 1);
            end
         end
         ST_HOLD: begin
            if (tmr_zero) begin
               st_d     = ST_PROG;
               tmr_load = 1'b1;
               tmr_val  = TMR_W'(PROG_LOW_CYC - 1);
            end
         end
         ST_PROG: begin
            if (tmr_zero) begin
               if (left_q == '0) begin
                  st_d   = ST_IDLE;
                  finish = 1'b1;
               end else begin
                  st_d = ST_FETCH;
               end
            end
         end
         ST_FETCH: begin
            if (word_valid_i) begin
               take = 1'b1;
               go   = 1'b1;
               st_d = ST_SHIFT;
            end
         end
         ST_SHIFT: begin
            if (word_end) begin
               if (left_q == CNT_W'(1)) begin
                  st_d   = ST_IDLE;
                  finish = 1'b1;
               end else begin
                  st_d = ST_FETCH;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         left_q <= '0;
         rev_q  <= 1'b0;
         pwr_q  <= 1'b0;
         done_q <= 1'b0;
         word_q <= '0;
      end else begin
         st_q   <= st_d;
         done_q <= finish;
         if (launch) begin
            left_q <= word_count_i;
            rev_q  <= byte_rev_i;
            pwr_q  <= 1'b1;
         end else if (st_q == ST_SHIFT && word_end) begin
            left_q <= left_q - 1'b1;
         end
         if (take) begin
            word_q <= word_data_i;
         end
      end
   end

   assign msb_pos       = LO_W'(BYTE_W - 1) - bit_idx[LO_W-1:0];
   assign word_ready_o  = (st_q == ST_FETCH);
   assign pwr_en_o      = pwr_q;
   assign cfg_reset_n_o = (st_q != ST_PROG);
   assign cfg_clk_o     = clk_hi;
   assign cfg_data_o    = (st_q == ST_SHIFT) && lane[msb_pos];
   assign busy_o        = (st_q != ST_IDLE);
   assign done_o        = done_q;

endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker (
   input logic clk,
   input logic rst_n,
   input logic pwr_en,
   input logic reset_n,
   input logic cclk,
   input logic data,
   input logic ready,
   input logic busy,
   input logic done
);

   AST_RESET_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
      !reset_n |-> pwr_en); // R2

   AST_CLOCK_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      cclk |-> (reset_n && busy)); // R2

   AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cclk) |-> $stable(data)); // R3

   AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cclk && $past(cclk)) |-> $stable(data)); // R3

   AST_READY_QUIET_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!cclk && busy && reset_n)); // R6

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R7

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_POWER_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_en |=> pwr_en); // R10

endmodule

bind cfg_serial_loader cfgl_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pwr_en  (pwr_en_o),
   .reset_n (cfg_reset_n_o),
   .cclk    (cfg_clk_o),
   .data    (cfg_data_o),
   .ready   (word_ready_o),
   .busy    (busy_o),
   .done    (done_o)
);

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;

   localparam int PWR = 6;
   localparam int HLD = 3;
   localparam int PRG = 5;
   localparam int HI  = 2;
   localparam int LO  = 3;
   localparam int CW  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [CW-1:0] cnt_in = '0;
   logic        rev_in = 1'b0;
   logic [31:0] wdata = '0;
   logic        wvalid = 1'b0;
   logic        wready, pwr_en, rst_cfg_n, cclk, cdata, busy, done;

   int total = 0;
   int bad = 0;
   bit cap [128];
   int cap_n = 0;
   int hs = 0;
   int ready_seen = 0;
   int hi_run = 0;
   int lo_run = 0;

   always #5ns clk = ~clk;

   cfg_serial_loader #(
      .WORD_W(32), .BYTE_W(8), .CNT_W(CW),
      .PWR_WAIT_CYC(PWR), .HOLD_CYC(HLD), .PROG_LOW_CYC(PRG),
      .CCLK_HI_CYC(HI), .CCLK_LO_CYC(LO), .REV_EN(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .word_count_i(cnt_in),
      .byte_rev_i(rev_in), .word_data_i(wdata), .word_valid_i(wvalid),
      .word_ready_o(wready), .pwr_en_o(pwr_en), .cfg_reset_n_o(rst_cfg_n),
      .cfg_clk_o(cclk), .cfg_data_o(cdata), .busy_o(busy), .done_o(done)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] wgen(input int seed, input int i);
      if (seed == 0) begin
         case (i)
            0: return 32'hFFFF_FFFF;
            1: return 32'hAA99_5566;
            2: return 32'h0000_0001;
            default: return 32'h80FF_0001;
         endcase
      end
      return (32'(seed) * 32'h9E37_79B9) ^ (32'(i) * 32'h3C6E_F372) ^ (32'h1 << ((seed * 7 + i) % 32));
   endfunction

   function automatic bit exp_bit(input logic [31:0] w, input bit rev, input int k);
      int b, i, ln;
      b  = k / 8;
      i  = 7 - (k % 8);
      ln = rev ? (3 - b) : b;
      return w[ln*8 + i];
   endfunction

   // capture data on every configuration clock rise
   always @(posedge cclk) begin
      if (cap_n < 128) cap[cap_n] = cdata;
      cap_n++;
   end

   // pulse-width and ready monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (wready) ready_seen++;
         if (cclk) begin
            if (hi_run == 0) chk(lo_run >= LO, "R3 low phase", lo_run, LO);
            hi_run++;
            lo_run = 0;
         end else begin
            if (hi_run != 0) chk(hi_run == HI, "R3 high phase", hi_run, HI);
            hi_run = 0;
            lo_run++;
         end
      end
   end

   task automatic feed(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         repeat ((i + seed) % 3) @(negedge clk);
         wvalid = 1'b1;
         wdata  = wgen(seed, i);
         while (!wready) @(negedge clk);
         @(negedge clk);
         wvalid = 1'b0;
         hs++;
      end
   endtask

   task automatic run(input int n, input bit rev, input int seed, input bit poke);
      int k, low, t, mism;
      cap_n = 0;
      hs = 0;
      ready_seen = 0;
      @(negedge clk);
      cnt_in = CW'(n);
      rev_in = rev;
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
      cnt_in = CW'(n + 2);   // R9: changes after the start must not matter
      rev_in = ~rev;
      chk(pwr_en == 1'b1, "R2 power on", pwr_en, 1);
      chk(busy == 1'b1, "R7 busy after start", busy, 1);
      fork
         feed(n, seed);
         begin
            k = 1;
            while (rst_cfg_n && k < 1000) begin
               if (cclk || cdata) chk(0, "R2 quiet link", {cclk, cdata}, 0);
               @(negedge clk);
               k++;
            end
            chk(k == PWR + HLD + 1, "R2 reset delay", k, PWR + HLD + 1);
            low = 0;
            while (!rst_cfg_n && low < 1000) begin
               if (cclk) chk(0, "R2 clock in reset", cclk, 0);
               low++;
               @(negedge clk);
            end
            chk(low == PRG, "R2 reset width", low, PRG);
            if (poke && n > 0) begin
               cnt_in = CW'(n + 1);
               start  = 1'b1;
               @(negedge clk);
               start  = 1'b0;
            end
            t = 0;
            while (!done && t < 20000) begin
               @(negedge clk);
               t++;
            end
            chk(done == 1'b1, "R7 done seen", done, 1);
            chk(busy == 1'b0, "R7 busy low at done", busy, 0);
            @(negedge clk);
            chk(done == 1'b0, "R7 done single cycle", done, 0);
            chk(pwr_en == 1'b1, "R10 power held", pwr_en, 1);
            chk(rst_cfg_n && !cclk, "R10 link idle", {rst_cfg_n, cclk}, 2);
         end
      join
      chk(hs == n, "R6 handshakes", hs, n);
      chk(cap_n == 32 * n, poke ? "R9 bit count with poke" : "R6 bit count", cap_n, 32 * n);
      if (n == 0) begin
         chk(ready_seen == 0, "R8 no ready", ready_seen, 0);
         chk(cap_n == 0, "R8 no pulses", cap_n, 0);
      end
      for (int w = 0; w < n && w < 4; w++) begin
         mism = 0;
         for (int b = 0; b < 32; b++)
            if (cap[w*32 + b] != exp_bit(wgen(seed, w), rev, b)) mism++;
         chk(mism == 0, rev ? "R5 reversed order" : "R4 normal order", mism, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!pwr_en && rst_cfg_n && !cclk && !cdata, "R1 reset outputs",
          {pwr_en, rst_cfg_n, cclk, cdata}, 4'b0100);
      chk(!wready && !busy && !done, "R1 reset status", {wready, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!pwr_en && !busy && !wready, "R1 after release", {pwr_en, busy, wready}, 0);
      for (int n = 0; n <= 4; n++)
         for (int r = 0; r < 2; r++)
            for (int s = 0; s < 3; s++)
               run(n, r[0], s, (s == 2));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule